// File: doc/BRIEF.md
# Dual-Input Up/Down Counter

A 4-bit presettable counter with two separate count-pulse inputs: a rising edge on the up input adds one, a rising edge on the down input subtracts one. Both count inputs are treated as asynchronous levels. Each passes through a two-flop synchronizer clocked by a free-running system clock, and its rising edge is then found on that clock. All state bits change on a single system clock edge, so the value never passes through intermediate codes.

A synchronous active-high clear zeroes the value and outranks everything else. An active-low load copies the parallel preset word into the value. Reloading a preset on terminal count turns the block into a modulo-N divider. Two active-low cascade outputs let stages be chained without glue logic: the up-overflow output follows the up input while the value sits at its maximum, and the down-underflow output follows the down input while the value is zero. Feed these outputs into the next stage's up and down inputs.

Top module: `updown_counter4`

## Requirements
- R1: While `rst_n` is low, and after it is released, `value` is 0 and both `carry_n` and `borrow_n` are 1.
- R2: A low-to-high transition on `up_clk`, with `down_clk` high and neither clear nor load active, increments `value` by one. The new value appears at the third rising `clk` edge after the input rises.
- R3: A low-to-high transition on `down_clk`, with `up_clk` high and neither clear nor load active, decrements `value` by one, with the same latency as R2.
- R4: Counting wraps modulo 16: counting up from 15 gives 0, and counting down from 0 gives 15.
- R5: When `load_n` is 0 at a rising `clk` edge and `clear` is 0, `value` takes `preset` on that edge, whatever the count inputs are doing.
- R6: When `clear` is 1 at a rising `clk` edge, `value` becomes 0 on that edge, regardless of `load_n`, `preset` and both count inputs.
- R7: `carry_n` is 0 exactly while `value` is 15 and the synchronized `up_clk` level (two `clk` edges late) is 0; it is 1 otherwise.
- R8: `borrow_n` is 0 exactly while `value` is 0 and the synchronized `down_clk` level is 0; it is 1 otherwise.
- R9: If synchronized rising edges of both count inputs are seen in the same `clk` cycle, `value` is left unchanged.
- R10: Two stages chained (low `carry_n` into high `up_clk`, low `borrow_n` into high `down_clk`) count as one 8-bit counter across the 15-to-0 and 0-to-15 boundaries of the low stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clear | input | 1 | Synchronous active-high clear, highest priority |
| load_n | input | 1 | Synchronous active-low parallel load |
| preset | input | 4 | Parallel preset word |
| up_clk | input | 1 | Count-up pulse input, idle high |
| down_clk | input | 1 | Count-down pulse input, idle high |
| value | output | 4 | Counter state |
| carry_n | output | 1 | Active-low overflow pulse for cascading up |
| borrow_n | output | 1 | Active-low underflow pulse for cascading down |

## Verification
The bench checks the wrap points in both directions. A counter that saturates, or that flags carry one count early, would leave the second stage of a chain at the wrong value. It checks that the cascade outputs stay high at value 14 while the up input is low, and at 15 while the up input is high. An implementation that decoded terminal count alone would pulse there. It checks priority by asserting clear together with load and a count, and load together with a count. It also checks that simultaneous edges on both inputs leave the value alone, which catches a design that lets one direction win.

// File: rtl/updown_counter4.sv
module updown_counter4 #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             up_clk,
  input  logic             down_clk,
  output logic [WIDTH-1:0] value,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam logic [WIDTH-1:0] TOP  = '1;
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [SYNC_STAGES-1:0] up_sync, dn_sync;
  logic                   up_prev, dn_prev;
  logic                   up_lvl, dn_lvl, up_rise, dn_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      up_sync <= '1;
      dn_sync <= '1;
      up_prev <= 1'b1;
      dn_prev <= 1'b1;
    end else begin
      up_sync <= {up_sync[SYNC_STAGES-2:0], up_clk};
      dn_sync <= {dn_sync[SYNC_STAGES-2:0], down_clk};
      up_prev <= up_lvl;
      dn_prev <= dn_lvl;
    end

  assign up_lvl  = up_sync[SYNC_STAGES-1];
  assign dn_lvl  = dn_sync[SYNC_STAGES-1];
  assign up_rise = up_lvl & ~up_prev;
  assign dn_rise = dn_lvl & ~dn_prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  value <= ZERO;
    else if (clear)              value <= ZERO;
    else if (!load_n)            value <= preset;
    else if (up_rise && !dn_rise) value <= value + ONE;
    else if (dn_rise && !up_rise) value <= value - ONE;

  assign carry_n  = !((value == TOP)  && !up_lvl);
  assign borrow_n = !((value == ZERO) && !dn_lvl);

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> value == ZERO);

  a_r5_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !load_n |=> value == $past(preset));

  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && load_n && up_rise && !dn_rise |=> value == $past(value) + ONE);

  a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && load_n && dn_rise && !up_rise |=> value == $past(value) - ONE);

  a_r9_tie_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && load_n && up_rise && dn_rise |=> $stable(value));

  a_r7_carry_only_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> borrow_n || (TOP == ZERO));

endmodule

// File: tb/tb_updown_counter4.sv
module tb_updown_counter4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0, load_n = 1'b1;
  logic [3:0] preset = 4'd0, preset_hi = 4'd0;
  logic       up_clk = 1'b1, down_clk = 1'b1;
  logic [3:0] value, value_hi;
  logic       carry_n, borrow_n, carry_hi_n, borrow_hi_n;
  int         tests = 0, fails = 0;

  always #5 clk = ~clk;

  updown_counter4 dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .preset(preset),
    .up_clk(up_clk), .down_clk(down_clk), .value(value),
    .carry_n(carry_n), .borrow_n(borrow_n));

  updown_counter4 dut_hi (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .preset(preset_hi),
    .up_clk(carry_n), .down_clk(borrow_n), .value(value_hi),
    .carry_n(carry_hi_n), .borrow_n(borrow_hi_n));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [3:0] lo, input logic [3:0] hi);
    @(negedge clk); preset = lo; preset_hi = hi; load_n = 1'b0;
    @(negedge clk); load_n = 1'b1;
  endtask

  task automatic pulse_up();
    @(negedge clk); up_clk = 1'b0;
    repeat (3) @(negedge clk);
    up_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_down();
    @(negedge clk); down_clk = 1'b0;
    repeat (3) @(negedge clk);
    down_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 value", value, 0);
    check("R1 carry_n", carry_n, 1);
    check("R1 borrow_n", borrow_n, 1);
  endtask

  task automatic t_count();
    do_load(4'd5, 4'd0);
    check("R5 load", value, 5);
    pulse_up();
    check("R2 up", value, 6);
    pulse_up();
    check("R2 up again", value, 7);
    pulse_down();
    check("R3 down", value, 6);
    // latency: raise at a negedge, value changes at the third posedge after it
    @(negedge clk); up_clk = 1'b0;
    repeat (3) @(negedge clk);
    up_clk = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 not yet", value, 6);
    @(negedge clk);
    check("R2 latency", value, 7);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_wrap_carry();
    do_load(4'd14, 4'd0);
    @(negedge clk); up_clk = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 no carry at 14", carry_n, 1);
    up_clk = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 no carry at 15 idle", carry_n, 1);
    up_clk = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 carry low", carry_n, 0);
    up_clk = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 wrap up", value, 0);
    check("R7 carry released", carry_n, 1);
  endtask

  task automatic t_wrap_borrow();
    do_load(4'd1, 4'd0);
    @(negedge clk); down_clk = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 no borrow at 1", borrow_n, 1);
    down_clk = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 no borrow at 0 idle", borrow_n, 1);
    down_clk = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 borrow low", borrow_n, 0);
    down_clk = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 wrap down", value, 15);
    check("R8 borrow released", borrow_n, 1);
  endtask

  task automatic t_priority();
    do_load(4'd9, 4'd0);
    @(negedge clk); up_clk = 1'b0; preset = 4'd3; load_n = 1'b0;
    repeat (3) @(negedge clk);
    up_clk = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 load over count", value, 3);
    load_n = 1'b1;
    @(negedge clk); clear = 1'b1; load_n = 1'b0; preset = 4'd12;
    @(negedge clk);
    check("R6 clear over load", value, 0);
    clear = 1'b0; load_n = 1'b1;
    do_load(4'd8, 4'd0);
    @(negedge clk); clear = 1'b1; down_clk = 1'b0;
    repeat (3) @(negedge clk);
    down_clk = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 clear over count", value, 0);
    clear = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_tie();
    do_load(4'd7, 4'd0);
    @(negedge clk); up_clk = 1'b0; down_clk = 1'b0;
    repeat (3) @(negedge clk);
    up_clk = 1'b1; down_clk = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 tie unchanged", value, 7);
  endtask

  task automatic t_cascade();
    do_load(4'd15, 4'd3);
    pulse_up();
    repeat (4) @(negedge clk);
    check("R10 low after up", value, 0);
    check("R10 high after up", value_hi, 4);
    pulse_down();
    repeat (4) @(negedge clk);
    check("R10 low after down", value, 15);
    check("R10 high after down", value_hi, 3);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_count();
    t_wrap_carry();
    t_wrap_borrow();
    t_priority();
    t_tie();
    t_cascade();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule